// File: doc/BRIEF.md
# DMA Channel Interrupt Status Aggregator

This block gathers the per-channel event pulses of a multi-channel DMA engine and turns them into one interrupt line. Every channel can report four kinds of event: a completion of class A (end of a whole transfer), a completion of class B (end of a flagged intermediate segment), and two fault classes. Each pulse is latched into a sticky raw status bit for its class. A per-class enable word selects which raw bits may reach the interrupt. The block presents each class's enabled view, a per-channel summary word and a single interrupt output.

Software reaches the block through a simple register port with one write strobe and one read strobe. It clears latched events by writing ones to the raw status words. It programs the enables and reads the status words. The port also carries a channel-busy word, which is fed in by the channel logic, and a priority word that software writes and the channel arbiter reads. The channel logic itself lies outside this block; only its pulses and busy flags enter.

Top module: `dma_evt_irq_agg`

## Requirements
- R1: After reset every raw bit, every enable bit and the priority word are zero, `irq` is low, and every mapped register reads 0.
- R2: A one-cycle pulse on bit i of an event input sets raw bit i of that class at the next clock edge. The bit stays set until software clears it. Raw words: completion A at 0x600, completion B at 0x608, fault A at 0x610, fault B at 0x618.
- R3: Writing a raw word clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R4: When an event pulse and a clearing write hit the same raw bit in the same cycle, the bit ends up set.
- R5: Enable words sit at 0x018 (completion A), 0x01C (completion B), 0x020 (fault A) and 0x024 (fault B), and an enable bit of 1 passes the event. Enabled-status words sit at 0x004, 0x008, 0x00C and 0x010, in the same class order, and each reads raw AND enable. Raw bits latch even while disabled.
- R6: Bit i of the summary word at 0x000 is the OR of the four enabled-status bits of channel i.
- R7: `irq` is the OR of all summary bits. Enabling a bit that is already pending raises `irq` right after the enabling write takes effect. Clearing the last pending enabled bit drops `irq`.
- R8: The word at 0x690 reads the `chan_busy` input. The priority word at 0x688 can be read and written and drives `prio_cfg`. A value of 0 means all channels have equal priority.
- R9: Read data appears on `reg_rdata` in the cycle after `reg_rd_en`. Unmapped addresses and unused upper bits read 0. Writes to the summary, enabled-status and busy words have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_done_a | input | NUM_CH | Completion class A pulses, one bit per channel |
| evt_done_b | input | NUM_CH | Completion class B pulses |
| evt_fault_a | input | NUM_CH | Fault class A pulses |
| evt_fault_b | input | NUM_CH | Fault class B pulses |
| chan_busy | input | NUM_CH | Per-channel busy flags |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, registered |
| prio_cfg | output | DATA_W | Priority word for the channel arbiter |
| irq | output | 1 | Combined interrupt |

## Verification
The bench latches events while they are disabled and checks that the raw words fill but `irq` stays low. It then enables them one class at a time, which separates the raw view from the enabled view and shows that the summary ORs across classes. Events on several classes of one channel, and on different channels, show whether the summary merges by channel rather than by class. A write that clears one bit while a pulse sets a neighbour, together with a same-bit collision, tells the set-wins rule apart from a plain clear. Writes to read-only words and reads of unmapped addresses confirm that nothing outside the map is touched.

// File: rtl/dma_irq_agg_pkg.sv
// Package: shared constants, class encoding and register offsets of the
// DMA interrupt aggregator. Offsets are fixed because software decodes them.
package dma_irq_agg_pkg;

    localparam int NUM_CLASSES = 4;

    // Class index order matches the order of the per-class register words.
    typedef enum logic [1:0] {
        EVC_DONE_A  = 2'd0,
        EVC_DONE_B  = 2'd1,
        EVC_FAULT_A = 2'd2,
        EVC_FAULT_B = 2'd3
    } evt_class_e;

    localparam logic [11:0] OFS_SUMMARY = 12'h000;
    localparam logic [11:0] OFS_ENSTAT0 = 12'h004;
    localparam logic [11:0] OFS_ENABLE0 = 12'h018;
    localparam logic [11:0] OFS_RAW0    = 12'h600;
    localparam logic [11:0] OFS_PRIO    = 12'h688;
    localparam logic [11:0] OFS_BUSY    = 12'h690;

    // Offset of the enabled-status word of class c (4-byte stride).
    function automatic logic [11:0] enstat_ofs(input int c);
        return OFS_ENSTAT0 + 12'(4 * c);
    endfunction

    // Offset of the enable word of class c (4-byte stride).
    function automatic logic [11:0] enable_ofs(input int c);
        return OFS_ENABLE0 + 12'(4 * c);
    endfunction

    // Offset of the raw word of class c (8-byte stride).
    function automatic logic [11:0] raw_ofs(input int c);
        return OFS_RAW0 + 12'(8 * c);
    endfunction

endpackage

// File: rtl/evt_class_bank.sv
// Module: evt_class_bank
// Holds the sticky raw event bits and the enable word of one event class.
// Assumes: evt pulses and clear writes are synchronous to clk; a pulse and
// a clear on the same bit in one cycle leave the bit set.
module evt_class_bank #(
    parameter int NUM_CH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] evt,
    input  logic              clr_we,
    input  logic [NUM_CH-1:0] clr_bits,
    input  logic              en_we,
    input  logic [NUM_CH-1:0] en_wdata,
    output logic [NUM_CH-1:0] raw,
    output logic [NUM_CH-1:0] enable,
    output logic [NUM_CH-1:0] enstat
);

    logic [NUM_CH-1:0] clr_eff;
    logic [NUM_CH-1:0] raw_next;

    // Clear mask applies only on a write strobe; new events override it.
    always_comb begin
        clr_eff  = clr_we ? clr_bits : '0;
        raw_next = (raw & ~clr_eff) | evt;
    end

    // Sticky raw status register.
    always_ff @(posedge clk) begin
        if (!rst_n) raw <= '0;
        else        raw <= raw_next;
    end

    // Enable word, written by software.
    always_ff @(posedge clk) begin
        if (!rst_n)     enable <= '0;
        else if (en_we) enable <= en_wdata;
    end

    // Enabled view of the raw bits.
    always_comb enstat = raw & enable;

    // R2 / R4: every pulsed bit is set one cycle later, whatever the clear.
    a_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (evt != '0) |=> ((raw & $past(evt)) == $past(evt)));

    // R3: bits cleared without a coinciding event read 0 next cycle.
    a_r3_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && ((clr_bits & ~evt) != '0)) |=> ((raw & $past(clr_bits & ~evt)) == '0));

    // R2: with no event and no clear, raw bits hold.
    a_r2_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_we && evt == '0) |=> $stable(raw));

endmodule

// File: rtl/irq_agg_regif.sv
// Module: irq_agg_regif
// Decodes the register port into per-class strobes, holds the priority word
// and returns registered read data. Assumes one access per strobe cycle;
// a read in the same cycle as a write returns the value before the write.
module irq_agg_regif
    import dma_irq_agg_pkg::*;
#(
    parameter int NUM_CH = 16,
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   reg_wr_en,
    input  logic                                   reg_rd_en,
    input  logic [ADDR_W-1:0]                      reg_addr,
    input  logic [DATA_W-1:0]                      reg_wdata,
    input  logic [NUM_CLASSES-1:0][NUM_CH-1:0]     raw,
    input  logic [NUM_CLASSES-1:0][NUM_CH-1:0]     enable,
    input  logic [NUM_CLASSES-1:0][NUM_CH-1:0]     enstat,
    input  logic [NUM_CH-1:0]                      summary,
    input  logic [NUM_CH-1:0]                      chan_busy,
    output logic [NUM_CLASSES-1:0]                 clr_we,
    output logic [NUM_CLASSES-1:0]                 en_we,
    output logic [NUM_CH-1:0]                      wr_bits,
    output logic [DATA_W-1:0]                      prio_cfg,
    output logic [DATA_W-1:0]                      reg_rdata
);

    logic [DATA_W-1:0] rd_next;
    logic              rd_hit;

    // Low data bits feed the per-channel registers.
    always_comb wr_bits = reg_wdata[NUM_CH-1:0];

    // Write decode: one strobe per class for clear and for enable.
    always_comb begin
        for (int c = 0; c < NUM_CLASSES; c++) begin
            clr_we[c] = reg_wr_en && (reg_addr == ADDR_W'(raw_ofs(c)));
            en_we[c]  = reg_wr_en && (reg_addr == ADDR_W'(enable_ofs(c)));
        end
    end

    // Priority word, software read/write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            prio_cfg <= '0;
        else if (reg_wr_en && reg_addr == ADDR_W'(OFS_PRIO))
            prio_cfg <= reg_wdata;
    end

    // Read multiplexer; unmapped addresses return zero.
    always_comb begin
        rd_next = '0;
        rd_hit  = 1'b0;
        if (reg_addr == ADDR_W'(OFS_SUMMARY)) begin
            rd_next = DATA_W'(summary);
            rd_hit  = 1'b1;
        end
        if (reg_addr == ADDR_W'(OFS_PRIO)) begin
            rd_next = prio_cfg;
            rd_hit  = 1'b1;
        end
        if (reg_addr == ADDR_W'(OFS_BUSY)) begin
            rd_next = DATA_W'(chan_busy);
            rd_hit  = 1'b1;
        end
        for (int c = 0; c < NUM_CLASSES; c++) begin
            if (reg_addr == ADDR_W'(enstat_ofs(c))) begin
                rd_next = DATA_W'(enstat[c]);
                rd_hit  = 1'b1;
            end
            if (reg_addr == ADDR_W'(enable_ofs(c))) begin
                rd_next = DATA_W'(enable[c]);
                rd_hit  = 1'b1;
            end
            if (reg_addr == ADDR_W'(raw_ofs(c))) begin
                rd_next = DATA_W'(raw[c]);
                rd_hit  = 1'b1;
            end
        end
    end

    // Registered read data, updated only on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)         reg_rdata <= '0;
        else if (reg_rd_en) reg_rdata <= rd_next;
    end

    // R9: an unmapped read returns zero.
    a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd_en && !rd_hit) |=> (reg_rdata == '0));

    // R8: the priority word takes the written value.
    a_r8_prio_write: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && reg_addr == ADDR_W'(OFS_PRIO)) |=> (prio_cfg == $past(reg_wdata)));

    // Decode sanity: at most one clear strobe per cycle.
    a_r3_one_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(clr_we));

endmodule

// File: rtl/dma_evt_irq_agg.sv
// Module: dma_evt_irq_agg (top)
// Latches four classes of per-channel DMA events, applies per-class enables,
// builds a per-channel summary and one interrupt line. Assumes NUM_CH is no
// wider than DATA_W and that event inputs are single-cycle pulses.
module dma_evt_irq_agg
    import dma_irq_agg_pkg::*;
#(
    parameter int NUM_CH = 16,
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] evt_done_a,
    input  logic [NUM_CH-1:0] evt_done_b,
    input  logic [NUM_CH-1:0] evt_fault_a,
    input  logic [NUM_CH-1:0] evt_fault_b,
    input  logic [NUM_CH-1:0] chan_busy,
    input  logic              reg_wr_en,
    input  logic              reg_rd_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [DATA_W-1:0] prio_cfg,
    output logic              irq
);

    logic [NUM_CLASSES-1:0][NUM_CH-1:0] evt_vec;
    logic [NUM_CLASSES-1:0][NUM_CH-1:0] raw_vec;
    logic [NUM_CLASSES-1:0][NUM_CH-1:0] en_vec;
    logic [NUM_CLASSES-1:0][NUM_CH-1:0] enstat_vec;
    logic [NUM_CLASSES-1:0]             clr_we;
    logic [NUM_CLASSES-1:0]             en_we;
    logic [NUM_CH-1:0]                  wr_bits;
    logic [NUM_CH-1:0]                  summary;

    // Pack the event inputs in class order.
    always_comb begin
        evt_vec[EVC_DONE_A]  = evt_done_a;
        evt_vec[EVC_DONE_B]  = evt_done_b;
        evt_vec[EVC_FAULT_A] = evt_fault_a;
        evt_vec[EVC_FAULT_B] = evt_fault_b;
    end

    // One storage bank per event class.
    for (genvar c = 0; c < NUM_CLASSES; c++) begin : g_bank
        evt_class_bank #(.NUM_CH(NUM_CH)) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .evt      (evt_vec[c]),
            .clr_we   (clr_we[c]),
            .clr_bits (wr_bits),
            .en_we    (en_we[c]),
            .en_wdata (wr_bits),
            .raw      (raw_vec[c]),
            .enable   (en_vec[c]),
            .enstat   (enstat_vec[c])
        );
    end

    // Per-channel summary: OR of the enabled bits across classes.
    always_comb begin
        summary = '0;
        for (int c = 0; c < NUM_CLASSES; c++)
            summary = summary | enstat_vec[c];
    end

    // Single interrupt output.
    always_comb irq = |summary;

    irq_agg_regif #(
        .NUM_CH (NUM_CH),
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_regif (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr_en (reg_wr_en),
        .reg_rd_en (reg_rd_en),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .raw       (raw_vec),
        .enable    (en_vec),
        .enstat    (enstat_vec),
        .summary   (summary),
        .chan_busy (chan_busy),
        .clr_we    (clr_we),
        .en_we     (en_we),
        .wr_bits   (wr_bits),
        .prio_cfg  (prio_cfg),
        .reg_rdata (reg_rdata)
    );

    // R7: the interrupt tracks the raw and enable state held in the banks.
    a_r7_irq_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (((raw_vec[0] & en_vec[0]) | (raw_vec[1] & en_vec[1]) |
                 (raw_vec[2] & en_vec[2]) | (raw_vec[3] & en_vec[3])) != '0));

    // R7: enabling a pending bit of completion class A raises irq next cycle.
    a_r7_unmask_raises: assert property (@(posedge clk) disable iff (!rst_n)
        (en_we[0] && ((reg_wdata[NUM_CH-1:0] & raw_vec[0]) != '0)) |=> irq);

    // R1: irq is low in the first cycle after reset.
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> !irq);

endmodule

// File: tb/dma_evt_irq_agg_bench.sv
// Directed bench for dma_evt_irq_agg: one task per scenario.
module dma_evt_irq_agg_bench;

    localparam int NUM_CH = 16;
    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NUM_CH-1:0] ev_da = '0, ev_db = '0, ev_fa = '0, ev_fb = '0;
    logic [NUM_CH-1:0] busy = '0;
    logic              wr_en = 1'b0, rd_en = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [DATA_W-1:0] wdata = '0;
    logic [DATA_W-1:0] rdata, prio;
    logic              irq;

    int n_chk = 0;
    int n_fail = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    dma_evt_irq_agg #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dma_evt_irq_agg (
        .clk(clk), .rst_n(rst_n),
        .evt_done_a(ev_da), .evt_done_b(ev_db), .evt_fault_a(ev_fa), .evt_fault_b(ev_fb),
        .chan_busy(busy), .reg_wr_en(wr_en), .reg_rd_en(rd_en), .reg_addr(addr),
        .reg_wdata(wdata), .reg_rdata(rdata), .prio_cfg(prio), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [11:0] a, input logic [31:0] exp);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        chk(tag, rdata, exp);
    endtask

    task automatic pulse(input logic [15:0] da, input logic [15:0] db,
                         input logic [15:0] fa, input logic [15:0] fb);
        @(negedge clk);
        ev_da = da; ev_db = db; ev_fa = fa; ev_fb = fb;
        @(negedge clk);
        ev_da = '0; ev_db = '0; ev_fa = '0; ev_fb = '0;
    endtask

    task automatic t_reset();
        chk("R1 irq", 32'(irq), 0);
        chk("R1 prio port", prio, 0);
        rd_chk("R1 summary", 12'h000, 0);
        rd_chk("R1 raw A", 12'h600, 0);
        rd_chk("R1 raw fault B", 12'h618, 0);
        rd_chk("R1 enable A", 12'h018, 0);
        rd_chk("R1 prio", 12'h688, 0);
    endtask

    task automatic t_latch_disabled();
        pulse(16'h0008, 0, 0, 16'h8000);
        chk("R5 irq low while disabled", 32'(irq), 0);
        rd_chk("R2 raw A ch3", 12'h600, 32'h0008);
        rd_chk("R2 raw fault B ch15", 12'h618, 32'h8000);
        rd_chk("R5 enstat A disabled", 12'h004, 0);
        rd_chk("R6 summary disabled", 12'h000, 0);
    endtask

    task automatic t_enable();
        wr(12'h018, 32'hFFFF);
        chk("R7 irq after enable", 32'(irq), 1);
        rd_chk("R5 enstat A", 12'h004, 32'h0008);
        rd_chk("R6 summary A only", 12'h000, 32'h0008);
        wr(12'h024, 32'h8000);
        rd_chk("R5 enstat fault B", 12'h010, 32'h8000);
        rd_chk("R6 summary two classes", 12'h000, 32'h8008);
        rd_chk("R5 enable readback", 12'h024, 32'h8000);
    endtask

    task automatic t_clear();
        wr(12'h618, 32'h0);
        rd_chk("R3 zero write keeps", 12'h618, 32'h8000);
        wr(12'h600, 32'h0008);
        rd_chk("R3 raw A cleared", 12'h600, 0);
        rd_chk("R6 summary after clear", 12'h000, 32'h8000);
        chk("R7 irq still pending", 32'(irq), 1);
        wr(12'h618, 32'hFFFF);
        chk("R7 irq drops", 32'(irq), 0);
    endtask

    task automatic t_set_wins();
        pulse(0, 16'h0040, 0, 0);
        @(negedge clk);
        ev_db = 16'h0020; wr_en = 1'b1; addr = 12'h608; wdata = 32'h0060;
        @(negedge clk);
        ev_db = '0; wr_en = 1'b0;
        rd_chk("R4 set beats clear", 12'h608, 32'h0020);
        wr(12'h608, 32'hFFFF);
    endtask

    task automatic t_multi_class();
        wr(12'h01C, 32'hFFFF);
        wr(12'h020, 32'hFFFF);
        pulse(16'h0001, 16'h0001, 16'h0002, 0);
        rd_chk("R6 summary merges by channel", 12'h000, 32'h0003);
        rd_chk("R5 enstat fault A", 12'h00C, 32'h0002);
        wr(12'h600, 32'h1); wr(12'h608, 32'h1);
        rd_chk("R6 summary after partial clear", 12'h000, 32'h0002);
        wr(12'h610, 32'h2);
        chk("R7 irq cleared", 32'(irq), 0);
    endtask

    task automatic t_misc();
        busy = 16'hA5A5;
        rd_chk("R8 busy", 12'h690, 32'h0000A5A5);
        wr(12'h688, 32'h0000_0003);
        chk("R8 prio port", prio, 32'h3);
        rd_chk("R8 prio readback", 12'h688, 32'h3);
        pulse(0, 0, 0, 16'h0100);
        wr(12'h010, 32'h0);
        wr(12'h000, 32'h0);
        wr(12'h690, 32'h0);
        rd_chk("R9 enstat write ignored", 12'h010, 0);
        rd_chk("R9 raw untouched", 12'h618, 32'h0100);
        rd_chk("R9 busy write ignored", 12'h690, 32'h0000A5A5);
        rd_chk("R9 unmapped", 12'h100, 0);
        wr(12'h018, 32'hFFFF_0000);
        rd_chk("R9 upper bits zero", 12'h018, 0);
    endtask

    // Watchdog: an expired run counts as a failure.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected below 100000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_latch_disabled();
        t_enable();
        t_clear();
        t_set_wins();
        t_multi_class();
        t_misc();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule